// File: doc/BRIEF.md
# Pager Frame Sync Correlator

This block scans a stream of sliced four-level baseband samples for the 64-bit synchronization word that opens every pager frame. The samples arrive oversampled at a fixed number of samples per bit. Each sample is reduced to a hard bit. A rotating phase index picks which of the per-phase history registers receives that bit, so every sampling position inside a bit period builds its own copy of the received bit sequence. A downstream timing-recovery stage then sees which phases are locked onto the sync word.

Each updated history word is checked in two stages. First, the central 32-bit marker is compared against a fixed constant with a tolerance of up to three bit errors. Only when the marker passes is the 32-bit outer code examined. The outer code is built from the leading and trailing 16-bit fields, and it is looked up in a mode table that is fixed at build time. Each table entry carries a code, a bit-rate selector and a level-count selector. The block reports a match flag, the index and attributes of the mode that matched, and a flag for a well-formed but unlisted code.

Top module: `pager_sync_corr`

## Requirements
- R1: A sample is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever `rst` is low. An accepted symbol value of 0 or 1 yields hard bit 1, and a value of 2 or 3 yields hard bit 0.
- R2: A phase index starts at 0, advances by one on each accepted sample, wraps from SPB-1 to 0, and holds while no sample is accepted. Only the history register selected by the current phase is updated, so the phases are independent.
- R3: The selected history register shifts left by one and the new hard bit enters at bit 0. In the 64-bit word, bits 63:48 are field A, bits 47:16 are the marker and bits 15:0 are field C.
- R4: The marker passes when it differs from 0xA6C6AAAA in at most 3 bit positions. With 4 or more differing bits, neither `sync_hit` nor `sync_unknown` is raised.
- R5: The outer code is {A, C}, with A in bits 31:16. Once the marker passes, `sync_hit` is raised when the code is within 3 bit errors of at least one table entry, and it is not raised at 4 or more errors from every entry.
- R6: When several entries are within tolerance, the lowest-numbered entry wins. `mode_idx` carries that entry number.
- R7: With `sync_hit` high, `mode_fast` shows the entry's bit-rate selector (1 means 3200 bit/s, 0 means 1600 bit/s) and `mode_four_level` shows the entry's level selector (1 means four-level, 0 means two-level). With `sync_hit` low, `mode_idx`, `mode_fast` and `mode_four_level` are 0.
- R8: `sync_unknown` is raised when the marker passes, no entry matches, and A XOR C equals 0xFFFF. It is never high together with `sync_hit`.
- R9: The result for an accepted sample is registered and appears on the outputs, with `out_valid` high, on the clock edge after the accepting edge. In a cycle that follows an edge with no accepted sample, `out_valid`, `sync_hit` and `sync_unknown` are 0.
- R10: Synchronous active-high reset clears every history register to 0, sets the phase to 0 and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_sym | input | 2 | Sliced symbol level, 0 to 3 |
| out_valid | output | 1 | Result of the previous accepted sample |
| sync_hit | output | 1 | Sync word with a listed mode detected |
| sync_unknown | output | 1 | Sync marker present with a well-formed, unlisted code |
| mode_idx | output | 3 | Table entry that matched |
| mode_fast | output | 1 | Matched mode uses 3200 bit/s |
| mode_four_level | output | 1 | Matched mode uses four levels |

## Verification
The correlator is driven with full sync words in which every bit is held for a whole bit period. The variants are: an exact listed code; three injected errors in both the marker and the code; four errors in the marker alone; four errors in the code alone; a complementary code that is absent from the table; and a code that lies within tolerance of two entries. Taken together, these separate the error threshold of each stage, the gating of the code check by the marker, the priority between entries and the unknown-code rule. A further pattern writes the sync word into a single sampling phase and its inverse into all the others, which shows that the phases are isolated. Gaps in `in_valid` show that the phase holds and that `out_valid` drops. Every sample is also compared with a bench model of the per-phase histories, and every symbol value is used for each hard bit.

// File: rtl/pgsync_pkg.sv
package pgsync_pkg;

    localparam int WORD_W     = 64;
    localparam int CODE_W     = 32;
    localparam int FIELD_W    = 16;
    localparam int MODE_IDX_W = 3;
    localparam int MAX_MODES  = 1 << MODE_IDX_W;
    localparam int MAX_ERR    = 3;

    localparam logic [31:0] SYNC_MARKER = 32'hA6C6_AAAA;

    // History word layout, MSB first
    typedef struct packed {
        logic [FIELD_W-1:0] fa;
        logic [31:0]        marker;
        logic [FIELD_W-1:0] fc;
    } sync_word_t;

    // Attributes of one table entry
    typedef struct packed {
        logic fast;
        logic four_level;
    } mode_attr_t;

    // Correlator verdict for one sample
    typedef struct packed {
        logic                  hit;
        logic                  unknown;
        logic [MODE_IDX_W-1:0] idx;
        mode_attr_t            attr;
    } corr_res_t;

    function automatic int unsigned popcnt32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    function automatic logic near32(input logic [31:0] a, input logic [31:0] b);
        return popcnt32(a ^ b) <= MAX_ERR;
    endfunction

    function automatic logic sym_to_bit(input logic [1:0] s);
        return s < 2'd2;
    endfunction

endpackage

// File: rtl/pgsync_phase_ctr.sv
module pgsync_phase_ctr #(
    parameter int SPB = 10,
    localparam int PW = (SPB > 1) ? $clog2(SPB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(SPB - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (step) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // R2: index stays inside the bit period
    p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    // R2: advance or wrap on an accepted sample
    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1));

    // R2: hold otherwise
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(phase));

endmodule

// File: rtl/pgsync_hist_bank.sv
module pgsync_hist_bank
    import pgsync_pkg::*;
#(
    parameter int SPB = 10,
    localparam int PW = (SPB > 1) ? $clog2(SPB) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PW-1:0]     phase,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-1:0] hist [SPB];
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < SPB; i++) begin
            if (phase == PW'(i)) sel_word = hist[i];
        end
    end

    // Updated word for the current phase, seen by the correlator this cycle
    assign word_next = {sel_word[WORD_W-2:0], bit_in};

    for (genvar g = 0; g < SPB; g++) begin : g_phase
        always_ff @(posedge clk) begin
            if (rst) begin
                hist[g] <= '0;
            end else if (wr_en && phase == PW'(g)) begin
                hist[g] <= word_next;
            end
        end

        // R3: register shifts left with the new bit at the LSB
        p_shift_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && phase == PW'(g)) |=>
                (hist[g][WORD_W-1:1] == $past(hist[g][WORD_W-2:0]) &&
                 hist[g][0] == $past(bit_in)));

        // R2: other phases untouched
        p_isolate_r2: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && phase == PW'(g)) |=> $stable(hist[g]));
    end

endmodule

// File: rtl/pgsync_match.sv
module pgsync_match
    import pgsync_pkg::*;
#(
    parameter int                        NUM_MODES = 8,
    parameter logic [NUM_MODES*32-1:0]   CODES     = '0,
    parameter logic [NUM_MODES-1:0]      FAST      = '0,
    parameter logic [NUM_MODES-1:0]      FOUR_LVL  = '0
) (
    input  logic [WORD_W-1:0] word_in,
    output corr_res_t         res
);
    sync_word_t        w;
    logic              marker_ok;
    logic [CODE_W-1:0] code;
    logic [NUM_MODES-1:0] hit_vec;

    assign w         = sync_word_t'(word_in);
    assign marker_ok = near32(w.marker, SYNC_MARKER);
    assign code      = {w.fa, w.fc};

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_entry
        assign hit_vec[g] = marker_ok && near32(code, CODES[g*32 +: 32]);
    end

    always_comb begin
        res         = '0;
        res.hit     = |hit_vec;
        res.unknown = marker_ok && !(|hit_vec) && ((w.fa ^ w.fc) == 16'hFFFF);
        // Lowest index wins: scan downward so the last assignment is the lowest
        for (int i = NUM_MODES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                res.idx             = MODE_IDX_W'(i);
                res.attr.fast       = FAST[i];
                res.attr.four_level = FOUR_LVL[i];
            end
        end
    end

endmodule

// File: rtl/pager_sync_corr.sv
module pager_sync_corr
    import pgsync_pkg::*;
#(
    parameter int                      SPB       = 10,
    parameter int                      NUM_MODES = 8,
    parameter logic [NUM_MODES*32-1:0] CODES     = {32'h71E3_8E1F, 32'h71E0_8E1F,
                                                    32'hC3A5_3C5A, 32'h6699_9966,
                                                    32'h3C3C_C3C3, 32'h0F0F_F0F0,
                                                    32'h5A5A_A5A5, 32'h1234_EDCB},
    parameter logic [NUM_MODES-1:0]    FAST      = 8'b1010_1010,
    parameter logic [NUM_MODES-1:0]    FOUR_LVL  = 8'b1100_1100,
    localparam int PW = (SPB > 1) ? $clog2(SPB) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] in_sym,
    output logic       out_valid,
    output logic       sync_hit,
    output logic       sync_unknown,
    output logic [2:0] mode_idx,
    output logic       mode_fast,
    output logic       mode_four_level
);
    logic              accept;
    logic [PW-1:0]     phase;
    logic [WORD_W-1:0] word_next;
    corr_res_t         res_d, res_q;
    logic              vld_q;

    initial begin
        assert (NUM_MODES >= 1 && NUM_MODES <= MAX_MODES)
            else $error("NUM_MODES out of range");
    end

    assign in_ready = !rst;
    assign accept   = in_valid && in_ready;

    pgsync_phase_ctr #(.SPB(SPB)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .step  (accept),
        .phase (phase)
    );

    pgsync_hist_bank #(.SPB(SPB)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept),
        .phase     (phase),
        .bit_in    (sym_to_bit(in_sym)),
        .word_next (word_next)
    );

    pgsync_match #(
        .NUM_MODES (NUM_MODES),
        .CODES     (CODES),
        .FAST      (FAST),
        .FOUR_LVL  (FOUR_LVL)
    ) u_match (
        .word_in (word_next),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= accept;
            res_q <= accept ? res_d : '0;
        end
    end

    assign out_valid       = vld_q;
    assign sync_hit        = res_q.hit;
    assign sync_unknown    = res_q.unknown;
    assign mode_idx        = res_q.idx;
    assign mode_fast       = res_q.attr.fast;
    assign mode_four_level = res_q.attr.four_level;

    // R9: one-cycle result latency
    p_lat_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!out_valid && !sync_hit && !sync_unknown));

    // R8: unknown and hit are exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(sync_hit && sync_unknown));

    // R6: a reported index lies inside the table
    p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
        sync_hit |-> (int'(mode_idx) < NUM_MODES));

    // R7: attributes are zero without a hit
    p_attr_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !sync_hit |-> (mode_idx == '0 && !mode_fast && !mode_four_level));

    // R1: ready tracks reset
    p_ready_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready);

endmodule

// File: tb/pager_sync_corr_tb.sv
module pager_sync_corr_tb_top;

    localparam int SPB = 10;
    localparam int NM  = 8;
    localparam logic [31:0] MARK = 32'hA6C6_AAAA;

    logic [31:0] tbl_code [NM] = '{32'h1234_EDCB, 32'h5A5A_A5A5, 32'h0F0F_F0F0, 32'h3C3C_C3C3,
                                   32'h6699_9966, 32'hC3A5_3C5A, 32'h71E0_8E1F, 32'h71E3_8E1F};
    logic [NM-1:0] tbl_fast = 8'b1010_1010;
    logic [NM-1:0] tbl_four = 8'b1100_1100;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [1:0] in_sym;
    logic       out_valid, sync_hit, sync_unknown, mode_fast, mode_four_level;
    logic [2:0] mode_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] mh [SPB];
    int          mph;

    always #10 clk = ~clk;

    pager_sync_corr dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .out_valid(out_valid), .sync_hit(sync_hit), .sync_unknown(sync_unknown),
        .mode_idx(mode_idx), .mode_fast(mode_fast), .mode_four_level(mode_four_level)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pc32(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [63:0] mk(input logic [31:0] code, input logic [31:0] mk_mark);
        return {code[31:16], mk_mark, code[15:0]};
    endfunction

    // One accepted sample; compares the outputs with the bench model
    task automatic send(input logic [1:0] s);
        logic [63:0] w;
        logic mok, hit, unk;
        logic [2:0] idx;
        @(negedge clk);
        in_valid = 1'b1;
        in_sym   = s;
        w        = {mh[mph][62:0], (s < 2'd2)};
        mh[mph]  = w;
        mph      = (mph + 1) % SPB;
        mok      = pc32(w[47:16] ^ MARK) < 4;
        hit = 0; idx = 0;
        for (int i = NM - 1; i >= 0; i--) begin
            if (mok && pc32({w[63:48], w[15:0]} ^ tbl_code[i]) < 4) begin
                hit = 1; idx = 3'(i);
            end
        end
        unk = mok && !hit && ((w[63:48] ^ w[15:0]) == 16'hFFFF);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R9 out_valid", 32'(out_valid), 1);
        chk(sync_hit === hit, "R4/R5 model hit", 32'(sync_hit), 32'(hit));
        chk(sync_unknown === unk, "R8 model unknown", 32'(sync_unknown), 32'(unk));
        chk(mode_idx === (hit ? idx : 3'd0), "R6 model idx", 32'(mode_idx), 32'(hit ? idx : 3'd0));
        chk(mode_fast === (hit ? tbl_fast[idx] : 1'b0), "R7 model fast", 32'(mode_fast), 32'(hit & tbl_fast[idx]));
    endtask

    // Each bit held for SPB samples, cycling through every symbol value
    task automatic send_word(input logic [63:0] w);
        for (int b = 63; b >= 0; b--) begin
            for (int r = 0; r < SPB; r++) begin
                send(w[b] ? ((r % 2 == 0) ? 2'd0 : 2'd1) : ((r % 2 == 0) ? 2'd2 : 2'd3));
            end
        end
    endtask

    task automatic expect_last(input string req, input bit hit, input bit unk,
                               input logic [2:0] idx, input bit fast, input bit four);
        chk(sync_hit === hit, {req, " hit"}, 32'(sync_hit), 32'(hit));
        chk(sync_unknown === unk, {req, " unknown"}, 32'(sync_unknown), 32'(unk));
        chk(mode_idx === idx, {req, " idx"}, 32'(mode_idx), 32'(idx));
        chk(mode_fast === fast, {req, " fast"}, 32'(mode_fast), 32'(fast));
        chk(mode_four_level === four, {req, " four"}, 32'(mode_four_level), 32'(four));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_sym = 2'd0;
        for (int p = 0; p < SPB; p++) mh[p] = '0;
        mph = 0;
        repeat (3) @(negedge clk);
        chk(in_ready === 1'b0, "R1 ready low in reset", 32'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 ready after reset", 32'(in_ready), 1);
        chk(out_valid === 1'b0, "R10 out_valid reset", 32'(out_valid), 0);
        expect_last("R10 reset", 0, 0, 0, 0, 0);
    endtask

    task automatic t_exact;
        send_word(mk(tbl_code[2], MARK));
        expect_last("R5 exact mode2", 1, 0, 3'd2, tbl_fast[2], tbl_four[2]);
    endtask

    task automatic t_three_err;
        send_word(mk(tbl_code[5] ^ 32'h8001_0100, MARK ^ 32'h0104_8000));
        expect_last("R4 R5 three errors", 1, 0, 3'd5, tbl_fast[5], tbl_four[5]);
        chk(mode_fast === 1'b1, "R7 fast mode5", 32'(mode_fast), 1);
    endtask

    task automatic t_marker_four;
        send_word(mk(tbl_code[1], MARK ^ 32'h1010_1010));
        expect_last("R4 marker four errors", 0, 0, 0, 0, 0);
    endtask

    task automatic t_code_four;
        send_word(mk(tbl_code[4] ^ 32'h0300_0030, MARK));
        expect_last("R5 code four errors", 0, 0, 0, 0, 0);
    endtask

    task automatic t_unknown;
        send_word(mk(32'h00FF_FF00, MARK));
        expect_last("R8 unlisted complement", 0, 1, 0, 0, 0);
        send_word(mk(32'h00FF_FF00, MARK ^ 32'hF000_0000));
        expect_last("R8 needs marker", 0, 0, 0, 0, 0);
    endtask

    task automatic t_priority;
        send_word(mk(tbl_code[7], MARK));
        expect_last("R6 priority to entry6", 1, 0, 3'd6, tbl_fast[6], tbl_four[6]);
        chk(mode_four_level === 1'b1, "R7 four entry6", 32'(mode_four_level), 1);
    endtask

    // Sync word only in phase 3, inverse everywhere else
    task automatic t_phase_iso;
        logic [63:0] w = mk(tbl_code[1], MARK);
        int hits = 0;
        while (mph != 0) send(2'd3);
        for (int b = 63; b >= 0; b--) begin
            for (int r = 0; r < SPB; r++) begin
                logic bv = (r == 3) ? w[b] : ~w[b];
                send(bv ? 2'd1 : 2'd2);
                if (b == 0 && sync_hit) hits++;
                if (b == 0 && r == 3)
                    chk(sync_hit === 1'b1 && mode_idx === 3'd1, "R2 phase3 hit", 32'(mode_idx), 1);
            end
        end
        chk(hits == 1, "R2 only one phase hits", 32'(hits), 1);
    endtask

    // Gaps in valid: no output, phase holds
    task automatic t_gaps;
        logic [63:0] w = mk(tbl_code[3], MARK);
        for (int b = 63; b >= 0; b--) begin
            for (int r = 0; r < SPB; r++) begin
                send(w[b] ? 2'd0 : 2'd3);
                if ((b + r) % 7 == 0) begin
                    @(negedge clk);
                    chk(out_valid === 1'b0 && sync_hit === 1'b0, "R9 idle cycle", 32'(out_valid), 0);
                end
            end
        end
        expect_last("R2 gaps mode3", 1, 0, 3'd3, tbl_fast[3], tbl_four[3]);
    endtask

    initial begin
        t_reset;
        t_exact;
        t_three_err;
        t_marker_four;
        t_code_four;
        t_unknown;
        t_priority;
        t_phase_iso;
        t_gaps;
        t_reset;
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule